// File: doc/BRIEF.md
# Two-Channel DMA Priority Arbiter

This block decides which of two DMA channels, read or write, receives the next bus tenure. Each channel's threshold logic raises a request when it is ready to transfer. Two configuration bits select the policy. If only the read bit is set, read always wins a contested decision. If only the write bit is set, write always wins. If both bits are set, or both are clear, the channels take turns, and read goes first after reset.

A decision is made only while the bus is free and neither channel holds a tenure. The chosen channel is registered into a one-hot select. That select stays fixed until the tenure-done pulse, so a request from the other channel never takes the bus away from the owner. The owner's bus engine uses the select, and it raises the done pulse when the transfer ends.

Top module: `dma_prio_arb`

## Requirements
- R1: After reset, sel_o is 2'b00 and the alternation pointer favours the read channel.
- R2: sel_o is one-hot or zero. Bit 0 means the read channel owns the bus and bit 1 means the write channel owns it.
- R3: When only one channel requests at an arbitration point, that channel is granted whatever the priority bits are.
- R4: With rd_prio_i=1 and wr_prio_i=0, a contested decision grants read.
- R5: With rd_prio_i=0 and wr_prio_i=1, a contested decision grants write.
- R6: With equal priority bits, contested decisions alternate between the channels, and the first alternating decision after reset goes to read.
- R7: The pointer moves to the channel that was not granted only when a tenure ends that was granted in alternating mode. Uncontested grants in alternating mode also move it. Tenures granted in a fixed mode leave it unchanged.
- R8: No grant is issued while bus_busy_i is high. A grant appears on sel_o one cycle after the arbitration point and then holds steady, whatever requests arrive, until tenure_done_i.
- R9: The cycle after tenure_done_i is sampled, sel_o returns to 2'b00. A new grant can appear on the following cycle.
- R10: A change to the priority bits during a tenure does not affect that tenure. The new setting applies at the next arbitration point.
- R11: A tenure_done_i pulse while no channel owns the bus has no effect on sel_o or on the pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_req_i | input | 1 | Read channel request condition met |
| wr_req_i | input | 1 | Write channel request condition met |
| rd_prio_i | input | 1 | Read priority configuration bit |
| wr_prio_i | input | 1 | Write priority configuration bit |
| bus_busy_i | input | 1 | Bus held by another agent; blocks arbitration |
| tenure_done_i | input | 1 | One-cycle pulse ending the current tenure |
| sel_o | output | 2 | One-hot owner select: bit 0 read, bit 1 write |

## Verification
The assertions assume two things about the inputs. First, tenure_done_i is a single-cycle pulse. Second, bus_busy_i reports only other agents, so it does not need to fall during an owned tenure. The stimulus pulses done for exactly one cycle per tenure and raises busy only while sel_o is zero. The stimulus also fires done once while the block is idle, to check that the pulse is ignored there. During each held tenure, the bench raises both requests and inverts both priority bits. This shows that neither the other channel's request nor a priority change disturbs the owner.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  localparam int unsigned NUM_CH = 2;
  localparam int unsigned CH_RD  = 0;
  localparam int unsigned CH_WR  = 1;

  typedef enum logic [1:0] {
    MODE_ALT = 2'd0,
    MODE_RD  = 2'd1,
    MODE_WR  = 2'd2
  } arb_mode_e;
endpackage

// File: rtl/dma_arb_mode.sv
module dma_arb_mode
  import dma_arb_pkg::*;
(
  input  logic      rd_prio_i,
  input  logic      wr_prio_i,
  output arb_mode_e mode_o
);
  always_comb begin
    unique case ({wr_prio_i, rd_prio_i})
      2'b01:   mode_o = MODE_RD;
      2'b10:   mode_o = MODE_WR;
      default: mode_o = MODE_ALT;
    endcase
  end
endmodule

// File: rtl/dma_arb_pick.sv
module dma_arb_pick
  import dma_arb_pkg::*;
(
  input  logic [NUM_CH-1:0] req_i,
  input  arb_mode_e         mode_i,
  input  logic              ptr_wr_i,  // 1: write is next in alternation
  output logic [NUM_CH-1:0] win_o
);
  logic wr_first;

  always_comb begin
    unique case (mode_i)
      MODE_RD: wr_first = 1'b0;
      MODE_WR: wr_first = 1'b1;
      default: wr_first = ptr_wr_i;
    endcase
  end

  always_comb begin
    win_o = '0;
    if (req_i[CH_RD] && req_i[CH_WR]) begin
      win_o[CH_WR] = wr_first;
      win_o[CH_RD] = !wr_first;
    end else begin
      win_o = req_i;
    end
  end
endmodule

// File: rtl/dma_arb_hold.sv
module dma_arb_hold
  import dma_arb_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [NUM_CH-1:0] win_i,
  input  logic              alt_i,
  input  logic              done_i,
  output logic [NUM_CH-1:0] sel_o,
  output logic              owned_o,
  output logic              ptr_wr_o
);
  logic alt_q;

  assign owned_o = |sel_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_o    <= '0;
      alt_q    <= 1'b0;
      ptr_wr_o <= 1'b0;
    end else if (owned_o) begin
      if (done_i) begin
        sel_o <= '0;
        if (alt_q) ptr_wr_o <= sel_o[CH_RD];
      end
    end else if (start_i) begin
      sel_o <= win_i;
      alt_q <= alt_i;
    end
  end
endmodule

// File: rtl/dma_prio_arb.sv
module dma_prio_arb
  import dma_arb_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       rd_req_i,
  input  logic       wr_req_i,
  input  logic       rd_prio_i,
  input  logic       wr_prio_i,
  input  logic       bus_busy_i,
  input  logic       tenure_done_i,
  output logic [1:0] sel_o
);
  arb_mode_e         mode;
  logic [NUM_CH-1:0] req, win, sel;
  logic              owned, ptr_wr, start;

  assign req[CH_RD] = rd_req_i;
  assign req[CH_WR] = wr_req_i;
  assign start      = !owned && !bus_busy_i && (|req);
  assign sel_o      = sel;

  dma_arb_mode u_mode (
    .rd_prio_i (rd_prio_i),
    .wr_prio_i (wr_prio_i),
    .mode_o    (mode)
  );

  dma_arb_pick u_pick (
    .req_i    (req),
    .mode_i   (mode),
    .ptr_wr_i (ptr_wr),
    .win_o    (win)
  );

  dma_arb_hold u_hold (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start),
    .win_i    (win),
    .alt_i    (mode == MODE_ALT),
    .done_i   (tenure_done_i),
    .sel_o    (sel),
    .owned_o  (owned),
    .ptr_wr_o (ptr_wr)
  );
endmodule

// File: rtl/dma_prio_arb_chk.sv
module dma_prio_arb_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       rd_req_i,
  input logic       wr_req_i,
  input logic       rd_prio_i,
  input logic       wr_prio_i,
  input logic       bus_busy_i,
  input logic       tenure_done_i,
  input logic [1:0] sel_o
);
  logic idle;
  assign idle = (sel_o == 2'b00);

  a_r2_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(sel_o));

  a_r8_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!idle && !tenure_done_i) |=> $stable(sel_o));

  a_r8_busy_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle && bus_busy_i) |=> idle);

  a_r9_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!idle && tenure_done_i) |=> idle);

  a_r3_sole_rd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle && !bus_busy_i && rd_req_i && !wr_req_i) |=> sel_o == 2'b01);

  a_r3_sole_wr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle && !bus_busy_i && !rd_req_i && wr_req_i) |=> sel_o == 2'b10);

  a_r4_fixed_rd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle && !bus_busy_i && rd_req_i && wr_req_i && rd_prio_i && !wr_prio_i)
      |=> sel_o == 2'b01);

  a_r5_fixed_wr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle && !bus_busy_i && rd_req_i && wr_req_i && !rd_prio_i && wr_prio_i)
      |=> sel_o == 2'b10);

  a_r11_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle && !rd_req_i && !wr_req_i) |=> idle);
endmodule

bind dma_prio_arb dma_prio_arb_chk u_chk (.*);

// File: tb/dma_prio_arb_bench.sv
module dma_prio_arb_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       rd_req_i = 1'b0, wr_req_i = 1'b0;
  logic       rd_prio_i = 1'b0, wr_prio_i = 1'b0;
  logic       bus_busy_i = 1'b0, tenure_done_i = 1'b0;
  logic [1:0] sel_o;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  bit finished = 1'b0;

  typedef struct {
    logic [1:0] exp;
    int         due;
    string      tag;
  } item_t;
  item_t q[$];

  dma_prio_arb u_dma_prio_arb (.*);

  always #2.5 clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  task automatic check(string tag, logic [1:0] act, logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: sel_o=%b expected %b (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic push(logic [1:0] exp, string tag);
    item_t it;
    it.exp = exp; it.due = cyc + 1; it.tag = tag;
    q.push_back(it);
  endtask

  // monitor
  always @(negedge clk_i) begin
    if (q.size() > 0 && q[0].due == cyc) begin
      item_t it;
      it = q.pop_front();
      check(it.tag, sel_o, it.exp);
    end
  end

  // one tenure: optional busy cycles, grant, hold under disturbance, release
  task automatic run(logic rd, logic wr, logic rp, logic wp, int busy_n,
                     logic [1:0] exp, string tag);
    for (int i = 0; i < busy_n; i++) begin
      @(posedge clk_i); #1;
      rd_req_i = rd; wr_req_i = wr; rd_prio_i = rp; wr_prio_i = wp;
      bus_busy_i = 1'b1;
      push(2'b00, "R8 busy");
    end
    @(posedge clk_i); #1;
    rd_req_i = rd; wr_req_i = wr; rd_prio_i = rp; wr_prio_i = wp;
    bus_busy_i = 1'b0;
    push(exp, tag);
    @(posedge clk_i); #1;            // R8/R10: other request and prio flip do not preempt
    rd_req_i = 1'b1; wr_req_i = 1'b1; rd_prio_i = !rp; wr_prio_i = !wp;
    push(exp, "R8 hold R10");
    @(posedge clk_i); #1;
    tenure_done_i = 1'b1;
    rd_req_i = 1'b0; wr_req_i = 1'b0;
    push(2'b00, "R9 release");
    @(posedge clk_i); #1;
    tenure_done_i = 1'b0;
    push(2'b00, "R9 idle");
  endtask

  initial begin
    repeat (2) @(posedge clk_i);
    #1 check("R1 reset", sel_o, 2'b00);
    rst_ni = 1'b1;
    run(1, 1, 0, 0, 0, 2'b01, "R6 first alt read");
    run(1, 1, 1, 1, 0, 2'b10, "R6 alt write");
    run(1, 1, 0, 0, 0, 2'b01, "R6 alt read");
    run(1, 0, 1, 0, 0, 2'b01, "R3 sole read");
    run(1, 1, 0, 0, 0, 2'b10, "R7 fixed kept ptr");
    run(1, 1, 0, 1, 0, 2'b10, "R5 fixed write");
    run(0, 1, 1, 0, 0, 2'b10, "R3 sole write vs rd prio");
    run(1, 1, 0, 0, 0, 2'b01, "R7 ptr kept after fixed");
    run(0, 1, 0, 0, 0, 2'b10, "R7 uncontested alt");
    run(1, 1, 0, 0, 0, 2'b01, "R7 ptr moved");
    run(1, 1, 1, 0, 0, 2'b01, "R4 fixed read");
    // R11: done while idle
    @(posedge clk_i); #1; tenure_done_i = 1'b1; push(2'b00, "R11 idle done");
    @(posedge clk_i); #1; tenure_done_i = 1'b0; push(2'b00, "R11 idle done");
    run(1, 1, 1, 1, 2, 2'b10, "R8 grant after busy R11");
    run(1, 1, 1, 0, 0, 2'b01, "R4 fixed read again");
    repeat (3) @(posedge clk_i);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk_i);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: run did not complete");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule